// File: doc/BRIEF.md
# Streaming Edge-Pair Midpoint Generator

The block takes one row of a binary edge image, one pixel per accepted cycle, in column order starting at column 0. Each new edge pixel is paired with every earlier edge pixel of the same row. For each such pair the block raises a flag at the pair's midpoint. Midpoints are counted in half-pixel steps, so the pair of columns i and j lands in slot i+j. Pairs that share a midpoint collapse into one flag.

Internally a pending-slot register holds, for the next column, the slots that earlier edge pixels would produce. This register advances one slot per accepted pixel. Each new edge pixel is injected two slots ahead of the previous one. The new pixel and the stored pattern move through the slot axis at different speeds, so every pair meets exactly once while the row is still arriving. No flush phase is needed after the last pixel.

A downstream accumulator adds up the flags per slot over many rows to locate a vertical symmetry axis. The flag vector from one pixel is valid on the cycle after that pixel is accepted.

Top module: `symmid_stream`

## Requirements
- R1: While reset is high and on the first cycle after it, `mid_valid`, `mid_flags` and `row_done` are all zero. Reset is synchronous and active high.
- R2: `mid_valid` is high exactly one cycle after each accepted pixel and low in every other cycle. A pixel is accepted when `pix_valid` is high, a row is open (or `row_start` is high in the same cycle), and fewer than N pixels have been accepted in that row.
- R3: When an accepted pixel at column c has `pix_edge`=1, bit c+j of `mid_flags` (bit 0 is slot 0) is set for every earlier column j<c of the same row whose pixel had `pix_edge`=1. No other bit is set. The top slot 2N-2 is never set.
- R4: When the accepted pixel has `pix_edge`=0, or when `mid_valid` is low, `mid_flags` is all zero.
- R5: A cycle with `pix_valid` low does not advance the column and does not change any later flag vector.
- R6: `row_start` opens a new row at column 0 and discards all edge history. A pixel presented in the same cycle as `row_start` becomes column 0 of the new row.
- R7: `row_end` in an open row closes it, and `row_done` pulses one cycle later. A pixel presented with `row_end` is still accepted. Pixels presented after the close and before the next `row_start` are not accepted and produce no `mid_valid`.
- R8: Pixels presented after N pixels have been accepted in a row are not accepted and do not alter any flag vector.
- R9: A pixel accepted at column 0 always yields an all-zero flag vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_edge | input | 1 | Edge value of the presented pixel |
| row_start | input | 1 | Opens a new row; this cycle's pixel is column 0 |
| row_end | input | 1 | Closes the open row after this cycle |
| mid_valid | output | 1 | Flag vector below belongs to the pixel accepted last cycle |
| mid_flags | output | 2N-1 | Midpoint flags in half-pixel slots |
| row_done | output | 1 | One-cycle pulse after a row is closed |

## Verification
The bench builds the block with N=8, which gives a 15-slot flag vector. With that width, a completely filled row followed by overflow pixels can be reached within a few cycles, as can an all-edge row in which many pairs merge onto the same slot. Rows made from a shift-register sequence cover irregular edge spacing. Stalls are placed between pixels, restarts arrive in the middle of a row, and `row_start` coincides with a pixel. A row closed by `row_end` without a pixel is also covered. All of these are compared each cycle against a model that recomputes every pair from the stored edge columns.

// File: rtl/symmid_pkg.sv
package symmid_pkg;

    typedef enum logic {
        ROW_IDLE = 1'b0,
        ROW_OPEN = 1'b1
    } row_state_e;

    // One decoded input step, produced by the column tracker.
    typedef struct packed {
        logic take;      // pixel is accepted this cycle
        logic edge_bit;  // edge value of the pixel
        logic fresh;     // a new row begins this cycle
        logic close;     // the open row ends after this cycle
    } step_t;

    function automatic int slot_count(input int n);
        return 2 * n - 1;
    endfunction

    function automatic int col_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/symmid_col_tracker.sv
module symmid_col_tracker
    import symmid_pkg::*;
#(
    parameter int N  = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_valid,
    input  logic          pix_edge,
    input  logic          row_start,
    input  logic          row_end,
    output step_t         step,
    output logic [CW-1:0] col_now
);

    row_state_e    state_q;
    logic [CW-1:0] col_q;
    logic          open_now;
    logic          room;

    always_comb begin
        open_now      = row_start || (state_q == ROW_OPEN);
        col_now       = row_start ? '0 : col_q;
        room          = col_now < CW'(N);
        step.take     = pix_valid && open_now && room;
        step.edge_bit = pix_edge;
        step.fresh    = row_start;
        step.close    = row_end && open_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ROW_IDLE;
            col_q   <= '0;
        end else begin
            if (row_start) col_q <= '0;
            if (step.take) col_q <= col_now + CW'(1);
            if (step.close)     state_q <= ROW_IDLE;
            else if (row_start) state_q <= ROW_OPEN;
        end
    end

    // R8: the column count never passes the row width
    a_r8_col_bound: assert property (@(posedge clk) disable iff (rst)
        col_q <= CW'(N));

    // R7: a closed row accepts nothing until reopened
    a_r7_closed_no_take: assert property (@(posedge clk) disable iff (rst)
        (state_q == ROW_IDLE && !row_start) |-> !step.take);

endmodule

// File: rtl/symmid_slot_reg.sv
module symmid_slot_reg #(
    parameter int N  = 16,
    parameter int S  = 31,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          edge_bit,
    input  logic          fresh,
    input  logic [CW-1:0] col_now,
    output logic [S-1:0]  pend
);

    // Slots that earlier edges would form with the next column. The
    // register advances by one slot per pixel, while the injection point
    // advances by two, so each new pixel meets every stored edge once.
    logic [S-1:0] inj;
    logic [S-1:0] base;

    for (genvar s = 0; s < S; s++) begin : g_inj
        if (s % 2 == 1) begin : g_odd
            assign inj[s] = edge_bit && (col_now == CW'((s - 1) / 2));
        end else begin : g_even
            assign inj[s] = 1'b0;
        end
    end

    always_comb base = fresh ? '0 : (pend << 1);

    always_ff @(posedge clk) begin
        if (rst)        pend <= '0;
        else if (take)  pend <= base | inj;
        else if (fresh) pend <= '0;
    end

    // R6: a restart without a pixel leaves no history behind
    a_r6_fresh_clears: assert property (@(posedge clk) disable iff (rst)
        (fresh && !take) |=> (pend == '0));

    // R5: a stall holds the pending pattern
    a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (!take && !fresh) |=> $stable(pend));

endmodule

// File: rtl/symmid_stream.sv
module symmid_stream
    import symmid_pkg::*;
#(
    parameter int N = 16,
    localparam int S  = slot_count(N),
    localparam int CW = col_width(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pix_valid,
    input  logic         pix_edge,
    input  logic         row_start,
    input  logic         row_end,
    output logic         mid_valid,
    output logic [S-1:0] mid_flags,
    output logic         row_done
);

    step_t         step;
    logic [CW-1:0] col_now;
    logic [S-1:0]  pend;
    logic [S-1:0]  flags_d;

    symmid_col_tracker #(.N(N), .CW(CW)) u_track (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_edge  (pix_edge),
        .row_start (row_start),
        .row_end   (row_end),
        .step      (step),
        .col_now   (col_now)
    );

    symmid_slot_reg #(.N(N), .S(S), .CW(CW)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .take     (step.take),
        .edge_bit (step.edge_bit),
        .fresh    (step.fresh),
        .col_now  (col_now),
        .pend     (pend)
    );

    // Pairing AND bank: the new edge gates the whole pending pattern.
    always_comb begin
        if (step.take && step.edge_bit && !step.fresh) flags_d = pend;
        else                                           flags_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_valid <= 1'b0;
            mid_flags <= '0;
            row_done  <= 1'b0;
        end else begin
            mid_valid <= step.take;
            mid_flags <= flags_d;
            row_done  <= step.close;
        end
    end

    a_r2_valid_needs_pixel: assert property (@(posedge clk) disable iff (rst)
        mid_valid |-> $past(pix_valid));

    a_r4_quiet_flags: assert property (@(posedge clk) disable iff (rst)
        !mid_valid |-> (mid_flags == '0));

    a_r9_first_col_empty: assert property (@(posedge clk) disable iff (rst)
        (mid_valid && $past(row_start)) |-> (mid_flags == '0));

    a_r7_done_after_end: assert property (@(posedge clk) disable iff (rst)
        row_done |-> $past(row_end));

    a_r3_top_slot_clear: assert property (@(posedge clk) disable iff (rst)
        mid_flags[S-1] == 1'b0);

endmodule

// File: tb/test_symmid_stream.sv
module test_symmid_stream;

    localparam int N = 8;
    localparam int S = 2 * N - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pix_valid = 1'b0;
    logic         pix_edge = 1'b0;
    logic         row_start = 1'b0;
    logic         row_end = 1'b0;
    logic         mid_valid;
    logic [S-1:0] mid_flags;
    logic         row_done;

    symmid_stream #(.N(N)) i_symmid_stream (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_edge  (pix_edge),
        .row_start (row_start),
        .row_end   (row_end),
        .mid_valid (mid_valid),
        .mid_flags (mid_flags),
        .row_done  (row_done)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;
    bit comparing = 1'b0;

    // Behavioural reference model
    int           m_open = 0;
    int           m_col = 0;
    bit           m_edges [N];
    logic         e_valid = 1'b0;
    logic [S-1:0] e_flags = '0;
    logic         e_done = 1'b0;

    always @(posedge clk) begin
        int  ce;
        bit  opn;
        bit  take;
        logic [S-1:0] f;
        if (rst) begin
            m_open  = 0;
            m_col   = 0;
            e_valid = 1'b0;
            e_flags = '0;
            e_done  = 1'b0;
        end else begin
            opn  = row_start || (m_open != 0);
            ce   = row_start ? 0 : m_col;
            take = pix_valid && opn && (ce < N);
            f    = '0;
            if (take && pix_edge)
                for (int j = 0; j < ce; j++)
                    if (m_edges[j]) f[ce + j] = 1'b1;
            e_valid = take;
            e_flags = f;
            e_done  = row_end && opn;
            if (row_start) m_col = 0;
            if (take) begin
                m_edges[ce] = pix_edge;
                m_col = ce + 1;
            end
            if (row_end && opn) m_open = 0;
            else if (row_start) m_open = 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [S-1:0] act,
                         input logic [S-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (comparing && !finished) begin
            check(mid_valid === e_valid, "R2 mid_valid", S'(mid_valid), S'(e_valid));
            check(mid_flags === e_flags, "R3 mid_flags", mid_flags, e_flags);
            check(row_done === e_done, "R7 row_done", S'(row_done), S'(e_done));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected done", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic drive(input bit v, input bit e, input bit s, input bit en);
        @(negedge clk);
        pix_valid = v;
        pix_edge  = e;
        row_start = s;
        row_end   = en;
    endtask

    task automatic send_row(input logic [N-1:0] bits, input int stall_every);
        for (int c = 0; c < N; c++) begin
            drive(1'b1, bits[c], c == 0, c == N - 1);
            if (stall_every > 0 && (c % stall_every) == stall_every - 1)
                drive(1'b0, 1'b1, 1'b0, 1'b0);  // R5 stall cycle
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mid_valid === 1'b0 && row_done === 1'b0, "R1 reset controls",
              S'({mid_valid, row_done}), '0);
        check(mid_flags === '0, "R1 reset flags", mid_flags, '0);
        @(negedge clk);
        rst = 1'b0;
        comparing = 1'b1;
        // R1: first cycle after reset still quiet
        @(negedge clk);
        check(mid_valid === 1'b0 && mid_flags === '0, "R1 after reset",
              mid_flags, '0);

        // R3, R9: irregular edge row without stalls
        send_row(8'b1100_1101, 0);
        // R5: same row with stalls after every second pixel
        send_row(8'b1100_1101, 2);
        // R3: all-edge row, many pairs merge onto shared slots
        send_row(8'hFF, 0);

        // R8: fill a row, then keep presenting edge pixels
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        for (int c = 1; c < N + 3; c++) drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b1);  // R7: close without a pixel
        // R7: pixels after close are ignored
        for (int c = 0; c < 3; c++) drive(1'b1, 1'b1, 1'b0, 1'b0);

        // R6: restart in the middle of a row; history must be discarded
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b0);  // R6: restart without a pixel
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b1, 1'b0);  // R6: restart with a pixel, R9
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b0);

        // R4: rows of mixed patterns from a shift-register sequence
        for (int r = 0; r < 40; r++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            send_row(lfsr, r % 4);
        end
        repeat (3) drive(1'b0, 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule